// File: doc/BRIEF.md
# Bit-Clock Rate Select and Resync Unit

This unit sits between a strobed 8-bit serial voice port and the converter section of a telephony codec. A 3-bit rate select tells it what is on its clock input: either the bit clock itself (512, 1536, 2048 or 4096 kHz) or a 4096 kHz master clock paired with a slow 128 or 256 kHz bit clock. From the clock input it derives a single-cycle enable at 512 kHz for the converter, and it flags whether the port runs in synchronous or asynchronous mode.

In synchronous mode every clock is one bit of the strobed timeslot. The received byte is delivered in the cycle after its last bit, and the transmit byte is driven straight out with no frame delay. In asynchronous mode, the bit clock, the strobe and the serial input are brought into the master-clock domain through two-flop synchronizers. A bit is taken on each synchronized bit-clock rising edge. Received and transmitted bytes pass through a holding register that is swapped at every frame start, which adds exactly one frame of delay. The 512 kHz divider is also re-phased at every frame start, so that drift between the master clock and the frame rate cannot accumulate.

The rate select and mode are static pins. Change them only while reset is held.

Top module: `bitrate_resync`

## Requirements
- R1: `asyncMode` is 1 exactly for rate select codes 3'b100 and 3'b101, and 0 for the other six codes.
- R2: `tick512` is a one-cycle pulse repeating every N clocks, with the first pulse N-1 cycles after reset release. N is 1 for codes 000, 110 and 111, 3 for 001, 4 for 010, and 8 for 011, 100 and 101.
- R3: Synchronous receive: while `strobe` is high, `serIn` is taken once per clock, MSB first, for 8 clocks. `rxByte` shows the byte, and `rxValid` pulses for one cycle, in the cycle right after the 8th bit.
- R4: Synchronous transmit: `serOutEn` equals `strobe`. In the i-th strobe cycle (i = 0..7), `serOut` equals `txByte[7-i]`. Whenever `serOutEn` is 0, `serOut` is 0.
- R5: Asynchronous sampling: `bitClk`, `strobe` and `serIn` each pass through two flops. A bit is taken on each synchronized rising edge of `bitClk` while the synchronized strobe is high, with at most 8 bits per slot.
- R6: Asynchronous receive: a byte collected in frame n is loaded into `rxByte`, with a one-cycle `rxValid`, at the synchronized strobe rise of frame n+1. This is 2 clocks after `strobe` rises. No load happens if no byte was collected since the last frame start, and `rxByte` changes only together with `rxValid`.
- R7: Asynchronous transmit: the `txByte` value present at the start of frame n is sent MSB first in frame n+1. Frames sent before any capture carry 0. Each bit appears after its bit event and holds until the next bit event. `serOutEn` rises with the first bit event and falls once the synchronized strobe is low.
- R8: Asynchronous realignment: the 512 kHz divider is cleared at each synchronized strobe rise. `tick512` is therefore low for the next 7 cycles and high in the 8th.
- R9: After reset, `rxByte` is 0, and `rxValid` and `serOutEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Clock input: the bit clock in synchronous mode, the 4096 kHz master clock in asynchronous mode |
| rstN | input | 1 | Asynchronous reset, active low |
| rateSel | input | 3 | Rate select code; see R1 and R2 |
| strobe | input | 1 | Frame strobe, high for the 8-bit timeslot, repeating at 8 kHz |
| bitClk | input | 1 | Slow bit clock, used in asynchronous mode only |
| serIn | input | 1 | Serial receive data, MSB first |
| txByte | input | 8 | Byte from the converter to be transmitted |
| tick512 | output | 1 | One-cycle 512 kHz enable for the converter section |
| asyncMode | output | 1 | 1 when the asynchronous mode is selected |
| rxByte | output | 8 | Last received byte handed to the converter |
| rxValid | output | 1 | One-cycle pulse when rxByte is loaded |
| serOut | output | 1 | Serial transmit data, forced to 0 when not enabled |
| serOutEn | output | 1 | Transmit drive enable (high while the slot is driven) |

## Verification
The hardest state to reach is the asynchronous hand-over. A byte is held across a whole frame, and it must appear exactly at the next synchronized strobe rise, while the divider is re-phased in that same cycle. The bench reaches this by generating the slow bit clock and the strobe itself, in a known phase to the master clock. Each bit takes a fixed number of master cycles, and the gap before each frame is varied, so that the strobe lands in a different divider phase every time. Counting negative edges from the strobe rise then gives exact cycles for checking the load, the bit windows and the first tick after realignment. The first frame after reset is checked separately to confirm that it sends zeros and loads nothing.

// File: rtl/ratesync_pkg.sv
package ratesync_pkg;

  localparam int BYTE_W    = 8;
  localparam int IDX_W     = $clog2(BYTE_W);
  localparam int CNT_W     = $clog2(BYTE_W + 1);
  localparam int MAX_RATIO = 8;
  localparam int DIV_W     = $clog2(MAX_RATIO);

  // strobes from control to datapath
  typedef struct packed {
    logic             asyncMode;
    logic             slotOn;
    logic             take;
    logic             lastBit;
    logic             frameStart;
    logic             dataBit;
    logic [IDX_W-1:0] bitIdx;
  } ctl_t;

  // divide ratio from clock input down to the 512 kHz converter rate
  function automatic int unsigned divRatio(input logic [2:0] sel);
    case (sel)
      3'b001:  return 3;
      3'b010:  return 4;
      3'b011:  return 8;
      3'b100:  return 8;
      3'b101:  return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic isSlowCode(input logic [2:0] sel);
    return sel[2] & ~sel[1];
  endfunction

endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import ratesync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clkIn,
  input  logic       rstN,
  input  logic [2:0] rateSel,
  input  logic       strobe,
  input  logic       bitClk,
  input  logic       serIn,
  output ctl_t       ctl,
  output logic       tick512
);
  logic             slowMode;
  logic [2:0]       syncOut;
  logic             bcLast;
  logic             bcEdge;
  logic             stbQ;
  logic             dQ;
  logic             bitEv;
  logic             stbPrev;
  logic             frameStart;
  logic [CNT_W-1:0] bitCnt;
  logic             take;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] ratioM1;

  assign slowMode = isSlowCode(rateSel);

  brs_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk (clkIn),
    .rstN(rstN),
    .d   ({bitClk, strobe, serIn}),
    .q   (syncOut)
  );

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) bcLast <= 1'b0;
    else       bcLast <= syncOut[2];
  end

  assign bcEdge = syncOut[2] & ~bcLast;
  assign stbQ   = slowMode ? syncOut[1] : strobe;
  assign dQ     = slowMode ? syncOut[0] : serIn;
  assign bitEv  = slowMode ? bcEdge : 1'b1;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) stbPrev <= 1'b0;
    else       stbPrev <= stbQ;
  end
  assign frameStart = stbQ & ~stbPrev;

  assign take = stbQ & bitEv & (bitCnt < CNT_W'(BYTE_W));

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN)      bitCnt <= '0;
    else if (!stbQ) bitCnt <= '0;
    else if (take)  bitCnt <= bitCnt + 1'b1;
  end

  // 512 kHz enable divider, re-phased on each frame start when slow
  assign ratioM1 = DIV_W'(divRatio(rateSel) - 1);
  assign tick512 = (divCnt >= ratioM1);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN)                        divCnt <= '0;
    else if (slowMode && frameStart)  divCnt <= '0;
    else if (tick512)                 divCnt <= '0;
    else                              divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    ctl            = '0;
    ctl.asyncMode  = slowMode;
    ctl.slotOn     = stbQ;
    ctl.take       = take;
    ctl.lastBit    = take & (bitCnt == CNT_W'(BYTE_W - 1));
    ctl.frameStart = frameStart;
    ctl.dataBit    = dQ;
    ctl.bitIdx     = bitCnt[IDX_W-1:0];
  end
endmodule

// File: rtl/brs_data.sv
module brs_data
  import ratesync_pkg::*;
(
  input  logic              clkIn,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [BYTE_W-1:0] txByte,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  output logic              serOut,
  output logic              serOutEn
);
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] assembled;
  logic [BYTE_W-1:0] rxHold;
  logic              holdFull;
  logic [BYTE_W-1:0] txHold;
  logic [BYTE_W-1:0] txOut;
  logic [BYTE_W-1:0] txCur;
  logic              txBitReg;
  logic              slowEn;
  logic [IDX_W-1:0]  txIdx;

  assign assembled = {rxShift[BYTE_W-2:0], ctl.dataBit};
  assign txIdx     = IDX_W'(BYTE_W - 1) - ctl.bitIdx;
  assign txCur     = ctl.frameStart ? txHold : txOut;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      rxHold   <= '0;
      holdFull <= 1'b0;
      rxByte   <= '0;
      rxValid  <= 1'b0;
      txHold   <= '0;
      txOut    <= '0;
    end else begin
      rxValid <= 1'b0;
      if (ctl.take) rxShift <= assembled;
      if (!ctl.asyncMode) begin
        if (ctl.lastBit) begin
          rxByte  <= assembled;
          rxValid <= 1'b1;
        end
      end else begin
        if (ctl.lastBit) begin
          rxHold   <= assembled;
          holdFull <= 1'b1;
        end
        if (ctl.frameStart) begin
          if (holdFull) begin
            rxByte   <= rxHold;
            rxValid  <= 1'b1;
            holdFull <= 1'b0;
          end
          txHold <= txByte;
          txOut  <= txHold;
        end
      end
    end
  end

  // slow-mode transmit bit, held from one bit event to the next
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      txBitReg <= 1'b0;
      slowEn   <= 1'b0;
    end else if (ctl.take) begin
      txBitReg <= txCur[txIdx];
      slowEn   <= 1'b1;
    end else if (!ctl.slotOn) begin
      slowEn   <= 1'b0;
    end
  end

  assign serOutEn = ctl.asyncMode ? slowEn : ctl.slotOn;
  assign serOut   = serOutEn & (ctl.asyncMode ? txBitReg : txByte[txIdx]);
endmodule

// File: rtl/bitrate_resync.sv
module bitrate_resync
  import ratesync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  logic [2:0]        rateSel,
  input  logic              strobe,
  input  logic              bitClk,
  input  logic              serIn,
  input  logic [BYTE_W-1:0] txByte,
  output logic              tick512,
  output logic              asyncMode,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  output logic              serOut,
  output logic              serOutEn
);
  ctl_t ctl;

  brs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkIn  (clkIn),
    .rstN   (rstN),
    .rateSel(rateSel),
    .strobe (strobe),
    .bitClk (bitClk),
    .serIn  (serIn),
    .ctl    (ctl),
    .tick512(tick512)
  );

  brs_data u_data (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .ctl     (ctl),
    .txByte  (txByte),
    .rxByte  (rxByte),
    .rxValid (rxValid),
    .serOut  (serOut),
    .serOutEn(serOutEn)
  );

  assign asyncMode = ctl.asyncMode;
endmodule

// File: rtl/brs_checker.sv
module brs_checker (
  input logic       clkIn,
  input logic       rstN,
  input logic [2:0] rateSel,
  input logic [7:0] rxByte,
  input logic       rxValid,
  input logic       tick512,
  input logic       asyncMode,
  input logic       serOut,
  input logic       serOutEn
);
  logic multiCode;
  assign multiCode = (rateSel == 3'b001) || (rateSel == 3'b010) || (rateSel == 3'b011)
                  || (rateSel == 3'b100) || (rateSel == 3'b101);

  assert_slow_code_R1: assert property (@(posedge clkIn) disable iff (!rstN)
    asyncMode |-> (rateSel[2] && !rateSel[1]));

  assert_tick_single_R2: assert property (@(posedge clkIn) disable iff (!rstN)
    (tick512 && multiCode) |=> (!tick512 || rateSel != $past(rateSel)));

  assert_valid_pulse_R3: assert property (@(posedge clkIn) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_quiet_low_R4: assert property (@(posedge clkIn) disable iff (!rstN)
    !serOutEn |-> !serOut);

  assert_rx_change_R6: assert property (@(posedge clkIn) disable iff (!rstN)
    !$stable(rxByte) |-> rxValid);
endmodule

bind bitrate_resync brs_checker u_chk (.*);

// File: tb/bitrate_resync_bench.sv
module bitrate_resync_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] rateSel = 3'b000;
  logic       strobe = 1'b0;
  logic       bitClk = 1'b0;
  logic       serIn = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       tick512, asyncMode, rxValid, serOut, serOutEn;
  logic [7:0] rxByte;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitrate_resync u_bitrate_resync (
    .clkIn(clk), .rstN(rstN), .rateSel(rateSel), .strobe(strobe),
    .bitClk(bitClk), .serIn(serIn), .txByte(txByte), .tick512(tick512),
    .asyncMode(asyncMode), .rxByte(rxByte), .rxValid(rxValid),
    .serOut(serOut), .serOutEn(serOutEn)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int expRatio(input int sel);
    if (sel == 1) return 3;
    if (sel == 2) return 4;
    if (sel == 3 || sel == 4 || sel == 5) return 8;
    return 1;
  endfunction

  task automatic do_reset(input logic [2:0] sel);
    @(negedge clk);
    rstN = 1'b0; rateSel = sel; strobe = 1'b0; bitClk = 1'b0;
    serIn = 1'b0; txByte = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sync_frame(input logic [7:0] rxb, input logic [7:0] txb);
    txByte = txb;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      strobe = 1'b1; serIn = rxb[7-i];
      #1;
      check("R4 sync serOut bit", serOut, txb[7-i]);
      check("R4 sync serOutEn", serOutEn, 1);
    end
    @(negedge clk);
    strobe = 1'b0;
    #1;
    check("R3 sync rxValid", rxValid, 1);
    check("R3 sync rxByte", rxByte, rxb);
    check("R4 sync enable off", serOutEn, 0);
    check("R4 sync serOut quiet", serOut, 0);
    @(negedge clk);
    #1;
    check("R3 sync rxValid single", rxValid, 0);
  endtask

  task automatic async_frame(input logic [7:0] rxb, input logic [7:0] txb, input int per,
                             input int expRx, input logic [7:0] expTx, input logic [7:0] oldRx,
                             input int idle);
    txByte = txb;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      bitClk = 1'b1; strobe = 1'b1; serIn = rxb[7-j];
      for (int s = 1; s < per; s++) begin
        @(negedge clk);
        if (s == per/2) bitClk = 1'b0;
        #1;
        if (j == 0 && s == 3) begin
          check("R6 async rxValid at frame start", rxValid, expRx >= 0 ? 1 : 0);
          check("R6 async rxByte at frame start", rxByte, expRx >= 0 ? expRx : oldRx);
        end
        if (j == 0 && s >= 3 && s <= 9) check("R8 tick low after realign", tick512, 0);
        if (j == 0 && s == 10) check("R8 tick after realign", tick512, 1);
        if (s == 8) begin
          check("R7 async serOut bit", serOut, expTx[7-j]);
          check("R5 async serOutEn", serOutEn, 1);
        end
      end
    end
    @(negedge clk);
    bitClk = 1'b1; strobe = 1'b0;
    for (int s = 1; s < per; s++) begin
      @(negedge clk);
      if (s == per/2) bitClk = 1'b0;
      #1;
      if (s == 4) begin
        check("R7 async enable off", serOutEn, 0);
        check("R5 no ninth bit load", rxValid, 0);
      end
    end
    repeat (idle) @(negedge clk);
  endtask

  initial begin
    // R1, R2, R9 across every select code
    for (int sel = 0; sel < 8; sel++) begin
      int cnt;
      int first;
      do_reset(3'(sel));
      #1;
      check("R9 reset rxValid", rxValid, 0);
      check("R9 reset serOutEn", serOutEn, 0);
      check("R9 reset rxByte", rxByte, 0);
      check("R1 mode flag", asyncMode, (sel == 4 || sel == 5) ? 1 : 0);
      cnt = 0; first = -1;
      for (int i = 0; i < 96; i++) begin
        if (tick512) begin
          cnt++;
          if (first < 0) first = i;
        end
        @(negedge clk);
        #1;
      end
      check("R2 tick count", cnt, 96 / expRatio(sel));
      check("R2 first tick", first, expRatio(sel) - 1);
    end

    // R3, R4 synchronous frames on every fast code
    for (int sel = 0; sel < 8; sel++) begin
      if (sel == 4 || sel == 5) continue;
      do_reset(3'(sel));
      for (int p = 0; p < 5; p++) begin
        logic [7:0] rb;
        rb = 8'(p * 8'h4B + sel * 8'h11 + 8'hA5);
        sync_frame(rb, rb ^ 8'h5A);
        repeat (p + 1) @(negedge clk);
      end
      sync_frame(8'hFF, 8'h00);
      sync_frame(8'h00, 8'hFF);
    end

    // R5..R8 asynchronous frames, one frame delay in both directions
    for (int sel = 4; sel <= 5; sel++) begin
      int per;
      int prevRx;
      logic [7:0] prevTx;
      logic [7:0] shown;
      per = (sel == 4) ? 32 : 16;
      do_reset(3'(sel));
      repeat (5) @(negedge clk);
      prevRx = -1; prevTx = 8'h00; shown = 8'h00;
      for (int f = 0; f < 6; f++) begin
        logic [7:0] rb;
        logic [7:0] tb;
        rb = 8'(f * 37 + 11 + sel);
        tb = 8'(f * 53 + 7);
        async_frame(rb, tb, per, prevRx, prevTx, shown, 40 + f * 3);
        if (prevRx >= 0) shown = 8'(prevRx);
        prevRx = rb;
        prevTx = tb;
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1..all act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule